// File: doc/BRIEF.md
# Fast Address-Gate and Reset Control Port

This block is a one-byte system control register on an 8-bit I/O bus. The register sits at a single port address, which is 0x92 by default. Software writes it to open or close the address line 20 gate quickly, without going through the keyboard controller. The same write can also ask the platform for a system reset. A read at the same address returns the byte last written.

The gate output is the register's gate bit ORed with a second gate request. That request comes from the keyboard-controller path. The reset request leaves as a pulse one clock long. The block has two resets. The power-on reset is asynchronous and clears the whole byte. The soft (device) reset clears only the reset-request bit, so the gate state and the other stored bits survive a system reset.

Top module: `sys_ctl_port`

## Requirements
- R1: After power-on reset (rst_ni low) the stored byte is 0x00, rst_req_o is 0, and gate_o equals kbc_gate_i.
- R2: A write (wr_i high) with addr_i equal to PORT_ADDR stores all eight bits of wdata_i at that clock edge.
- R3: gate_o is the OR of stored bit 1 and kbc_gate_i. It changes in the cycle after the write edge.
- R4: A write to PORT_ADDR with wdata_i bit 0 set makes rst_req_o high for exactly the one cycle after that edge. Each such write gives its own pulse.
- R5: rst_req_o stays low in any cycle that does not follow a matching write with bit 0 set.
- R6: soft_rst_i clears stored bit 0 and leaves bits 7..1 unchanged.
- R7: If soft_rst_i and a matching write occur in the same cycle, the stored byte becomes wdata_i with bit 0 cleared, and the reset pulse still fires when wdata_i bit 0 is set.
- R8: A write to any address other than PORT_ADDR, including one that differs only in the upper address bits, leaves the stored byte unchanged and gives no pulse.
- R9: rdata_o shows the stored byte while rd_i is high and addr_i equals PORT_ADDR. Otherwise rdata_o is 0x00.
- R10: Asserting rst_ni at any time clears the whole byte at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous device reset; clears the reset-request bit only |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; 0 when not selected |
| kbc_gate_i | input | 1 | Gate request from the keyboard-controller path |
| gate_o | output | 1 | Address line 20 gate enable |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong stored byte shows on rdata_o at the very next read of the port. If bit 1 is wrong, gate_o is also wrong in the cycle right after the write, except while kbc_gate_i is high and masks it. A wrong reset-request path appears as a missing, extra or stretched rst_req_o pulse in the cycle after the write. For that reason the bench samples that exact cycle and the one after it. A soft reset that clears the wrong bits appears on the next read as a changed upper bit or a bit 0 that is still set.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned RST_BIT  = 0;
  localparam int unsigned GATE_BIT = 1;
  localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;
endpackage

// File: rtl/sys_ctl_decode.sv
module sys_ctl_decode #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  PORT_ADDR = ADDR_W'('h92)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic sel;
  assign sel      = (addr_i == PORT_ADDR);
  assign wr_hit_o = wr_i & sel;
  assign rd_hit_o = rd_i & sel;
endmodule

// File: rtl/sys_ctl_reg.sv
module sys_ctl_reg
  import sys_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctl_q_o,
  output logic              req_q_o
);
  logic [DATA_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = wr_hit_i ? wdata_i : ctl_q;
    if (soft_rst_i) ctl_d = ctl_d & ~RST_MASK;  // soft reset touches only bit 0
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      req_q_o <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      req_q_o <= wr_hit_i & wdata_i[RST_BIT];
    end
  end

  assign ctl_q_o = ctl_q;

  a_r2_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_hit_i) && !$past(soft_rst_i) |-> ctl_q == $past(wdata_i));
  a_r6_soft_keeps_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i && !wr_hit_i |=> !ctl_q[RST_BIT] &&
      ctl_q[DATA_W-1:1] == $past(ctl_q[DATA_W-1:1]));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i && !soft_rst_i |=> $stable(ctl_q));
  a_r5_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q_o |-> $past(wr_hit_i) && $past(wdata_i[RST_BIT]));
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import sys_ctl_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'('h92)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              kbc_gate_i,
  output logic              gate_o,
  output logic              rst_req_o
);
  logic              wr_hit, rd_hit;
  logic [DATA_W-1:0] ctl_q;

  sys_ctl_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_decode (
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wr_hit_o(wr_hit),
    .rd_hit_o(rd_hit)
  );

  sys_ctl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .wr_hit_i  (wr_hit),
    .wdata_i   (wdata_i),
    .ctl_q_o   (ctl_q),
    .req_q_o   (rst_req_o)
  );

  assign gate_o  = ctl_q[GATE_BIT] | kbc_gate_i;
  assign rdata_o = rd_hit ? ctl_q : '0;

  a_r4_req_from_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == PORT_ADDR && wdata_i[RST_BIT] |=> rst_req_o);
  a_r8_miss_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == PORT_ADDR) |=> !rst_req_o);
  a_r3_gate_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbc_gate_i |-> gate_o);
endmodule

// File: tb/sys_ctl_port_bench.sv
module sys_ctl_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr[15:0], wdata[7:0], kbc, exp_rd[7:0], exp_gate, exp_req}
  localparam logic [34:0] VEC [NV] = '{
    {16'h0092, 8'h02, 1'b0, 8'h02, 1'b1, 1'b0},
    {16'h0092, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    {16'h0092, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},
    {16'h0092, 8'hA5, 1'b0, 8'hA5, 1'b0, 1'b1},
    {16'h0093, 8'hFF, 1'b0, 8'hA5, 1'b0, 1'b0},
    {16'h1092, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b0},
    {16'h0092, 8'h7E, 1'b0, 8'h7E, 1'b1, 1'b0},
    {16'h0092, 8'h7E, 1'b1, 8'h7E, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, soft_rst = 0, wr = 0, rd = 0, kbc = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        gate, req;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_ctl_port u_sys_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .kbc_gate_i(kbc), .gate_o(gate), .rst_req_o(req)
  );

  task automatic chk(string rq, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // drive at negedge, commit at posedge, return at the following negedge
  task automatic wr_cycle(logic [15:0] a, logic [7:0] d, logic s);
    @(negedge clk);
    addr = a; wdata = d; wr = 1; soft_rst = s;
    @(negedge clk);
    wr = 0; soft_rst = 0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    wr = 0; soft_rst = 0;
  endtask

  task automatic read_port(logic [15:0] a, output logic [7:0] v);
    addr = a; rd = 1; #1; v = rdata; rd = 0;
  endtask

  initial begin
    logic [7:0] v;
    #(CLK_PERIOD*3);
    #1; chk("R1 reset byte", 8'(u_sys_ctl_port.rdata_o), 8'h00);
    read_port(16'h0092, v); chk("R1 reset read", v, 8'h00);
    chk("R1 reset req", 8'(req), 8'h00);
    kbc = 1; #1; chk("R1 gate follows kbc", 8'(gate), 8'h01); kbc = 0;
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      kbc = VEC[i][10];
      wr_cycle(VEC[i][34:19], VEC[i][18:11], 1'b0);
      chk("R4/R5/R8 req after write", 8'(req), 8'(VEC[i][0]));
      chk("R3 gate", 8'(gate), 8'(VEC[i][1]));
      read_port(16'h0092, v); chk("R2/R8/R9 readback", v, VEC[i][9:2]);
    end
    kbc = 0;

    // R9: off-port and strobe-less reads give 0
    read_port(16'h0091, v); chk("R9 off-port read", v, 8'h00);
    addr = 16'h0092; #1; chk("R9 no strobe", rdata, 8'h00);

    // R4: back-to-back requests, then a quiet cycle
    @(negedge clk); addr = 16'h0092; wdata = 8'hFF; wr = 1;
    @(negedge clk); chk("R4 first pulse", 8'(req), 8'h01);
    @(negedge clk); wr = 0; chk("R4 second pulse", 8'(req), 8'h01);
    @(negedge clk); chk("R5 pulse ends", 8'(req), 8'h00);

    // R6: soft reset clears bit 0 only
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    read_port(16'h0092, v); chk("R6 soft reset", v, 8'hFE);
    chk("R6 gate kept", 8'(gate), 8'h01);
    chk("R6 no req", 8'(req), 8'h00);

    // R7: soft reset with concurrent write
    wr_cycle(16'h0092, 8'h83, 1'b1);
    chk("R7 req fires", 8'(req), 8'h01);
    read_port(16'h0092, v); chk("R7 stored", v, 8'h82);
    idle_cycle();
    chk("R5 quiet", 8'(req), 8'h00);

    // R10: asynchronous power-on reset mid-cycle
    #2; rst_n = 0; #1;
    read_port(16'h0092, v); chk("R10 async clear", v, 8'h00);
    chk("R10 gate clear", 8'(gate), 8'h00);
    @(negedge clk); rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD*5000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule